// File: doc/BRIEF.md
# Flash Module Bus Responder with Reset Bootstrap

This block is the slave side of an on-chip flash memory module sitting on a 16-bit processor bus. At reset it decides whether the module comes up disabled ("halted") or enabled. The decision comes from a nonvolatile halt bit and from a bus strap pin that is sampled while reset is held. When enabled, it can first claim the processor's four reset-vector fetches and serve four bootstrap words. After the last of those words has been read, it leaves the bootstrap role for good and decodes only its own address window.

In normal operation it answers byte, aligned-word and long-word reads. Each transfer's function code is checked against a 2-bit space selector. Program and erase requests follow flash bit rules on a small behavioural array: programming can only clear bits, and erasing sets whole blocks back to ones. Any access the module declines inside its decode is flagged with a no-acknowledge, so that another device on the bus can take it over. Each transfer is a one-cycle request. The answer is registered and appears on the cycle after the request.

Top module: `flash_bus_slave`

## Requirements
- R1: The module is halted at reset when `nv_halt` is 1 or `cfg_strap` is 0. While halted, every request inside the array window gets `nak` and never `ack`, and bootstrap addresses are not claimed at all. `ctl_op` = 2'b11 clears the halt.
- R2: Bootstrap is active only when reset ends with `nv_noboot` = 0 and the module not halted. While active, reads with `fc[1:0]` = 2'b10 at byte addresses 0, 2, 4 and 6 return bootstrap word k = `BOOT_VEC[16k+15:16k]` for k = 0..3, whatever the value of `space_sel`.
- R3: Once the word at address 6 has been delivered, bootstrap addresses are no longer claimed (neither `ack` nor `nak`). Only the array window is decoded after that.
- R4: A byte or word read gives `ack` with data on the cycle after the request, for one cycle. A byte read returns its byte in `rdata[7:0]` with `rdata[15:8]` = 0, and an even address selects the upper half of the word.
- R5: A long read (`size` = 2'b10, address with bits [1:0] = 0) gives `ack` on two consecutive cycles: first the word at the address, then the word at address+2.
- R6: Function codes are 2'b01 for data space and 2'b10 for program space, taken from `fc[1:0]`. `space_sel` selects which spaces are accepted: 00 both, 01 data only, 10 program only, 11 none. A window access in a space that is not accepted gets `nak`.
- R7: An address is inside the window when `addr - win_base` < 2*WORDS. Outside the window and outside active bootstrap, a request gets neither `ack` nor `nak`.
- R8: `ctl_op` = 2'b01 arms a program. The next accepted write ANDs `wdata` into one aligned word, or ANDs `wdata[7:0]` into one byte, so bits only change from 1 to 0. The write is acknowledged and uses up the arming.
- R9: `ctl_op` = 2'b10 arms an erase. The next accepted window write with `addr[3:1]` = k sets every word of block k (words k*WORDS/NBLK onward) to all ones when k < NBLK, and sets the whole array to ones otherwise. The array reads all ones after reset.
- R10: The following get `nak`, leave the array unchanged and keep any arming: writes without arming, long program writes, misaligned word or long accesses, and reads or programs with `size` = 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; configuration is sampled while low |
| cfg_strap | input | 1 | Data bus bit 15 level during reset; low forces halt |
| nv_halt | input | 1 | Nonvolatile halt bit (erased value 1) |
| nv_noboot | input | 1 | Nonvolatile bootstrap-disable bit (erased value 1) |
| win_base | input | AW | Byte base address of the array window |
| space_sel | input | 2 | Accepted address spaces |
| ctl_op | input | 2 | 00 none, 01 arm program, 10 arm erase, 11 leave halt |
| req | input | 1 | One-cycle transfer request |
| rw | input | 1 | 1 read, 0 write |
| size | input | 2 | 00 byte, 01 word, 10 long, 11 invalid |
| fc | input | 3 | Function code of the transfer |
| addr | input | AW | Byte address |
| wdata | input | 16 | Write data (byte data in bits 7:0) |
| ack | output | 1 | Transfer beat accepted |
| nak | output | 1 | Claimed transfer declined |
| rdata | output | 16 | Read data for the acknowledged beat |

## Verification
Several properties are checked on every cycle by the assertions. `ack` and `nak` never appear together. No first beat is acknowledged while the module was halted. The bootstrap state can never come back once it has ended. A long read always completes with exactly one second beat. Every program only clears bits of the word it touches. Other behaviour can only be shown by the bench's scenarios against its model: the reset decisions made from the straps, the actual bootstrap words, the byte-lane choice, the erase block decoding, and the fact that rejected writes leave memory and arming untouched.

// File: rtl/flash_pkg.sv
package flash_pkg;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_WORD = 2'b01;
  localparam logic [1:0] SZ_LONG = 2'b10;

  localparam logic [1:0] OP_ARM_PGM = 2'b01;
  localparam logic [1:0] OP_ARM_ERS = 2'b10;
  localparam logic [1:0] OP_RUN     = 2'b11;

  typedef enum logic [1:0] {ARM_NONE = 2'b00, ARM_PGM = 2'b01, ARM_ERS = 2'b10} arm_e;

  // Accepted address spaces for a given selector and function code.
  function automatic logic space_match(input logic [1:0] sel, input logic [2:0] fc);
    case (sel)
      2'b00:   return (fc[1:0] == 2'b01) || (fc[1:0] == 2'b10);
      2'b01:   return fc[1:0] == 2'b01;
      2'b10:   return fc[1:0] == 2'b10;
      default: return 1'b0;
    endcase
  endfunction

  // Alignment rule per transfer size.
  function automatic logic size_aligned(input logic [1:0] sz, input logic [1:0] a);
    case (sz)
      SZ_BYTE: return 1'b1;
      SZ_WORD: return ~a[0];
      SZ_LONG: return a == 2'b00;
      default: return 1'b0;
    endcase
  endfunction

  // Byte extraction: even address is the upper half.
  function automatic logic [15:0] pick_byte(input logic [15:0] w, input logic odd);
    return {8'h00, (odd ? w[7:0] : w[15:8])};
  endfunction

  // Bit lanes touched by a program write.
  function automatic logic [15:0] lane_mask(input logic [1:0] sz, input logic odd);
    if (sz == SZ_WORD) return 16'hFFFF;
    return odd ? 16'h00FF : 16'hFF00;
  endfunction

endpackage

// File: rtl/flash_decode.sv
module flash_decode
  import flash_pkg::*;
#(
  parameter int AW    = 24,
  parameter int WORDS = 64,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic [2:0]    fc,
  input  logic [1:0]    sel,
  input  logic [1:0]    size,
  input  logic          rw,
  input  logic          boot_act,
  output logic          hit_arr,
  output logic          hit_boot,
  output logic [IW-1:0] widx,
  output logic [1:0]    bidx,
  output logic          sp_ok,
  output logic          aligned
);
  localparam logic [AW-1:0] WIN_BYTES = AW'(2 * WORDS);

  logic [AW-1:0] off;

  assign off      = addr - base;
  assign hit_arr  = off < WIN_BYTES;
  assign widx     = off[IW:1];
  assign hit_boot = boot_act && rw && (fc[1:0] == 2'b10) && (addr[AW-1:3] == '0);
  assign bidx     = addr[2:1];
  assign sp_ok    = space_match(sel, fc);
  assign aligned  = size_aligned(size, addr[1:0]);

endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int WORDS = 64,
  parameter int NBLK  = 4,
  localparam int IW   = $clog2(WORDS),
  localparam int BW   = WORDS / NBLK
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_idx,
  output logic [15:0]   rd_word,
  input  logic          prog_en,
  input  logic [IW-1:0] prog_idx,
  input  logic [15:0]   prog_mask,
  input  logic [15:0]   prog_data,
  input  logic          erase_en,
  input  logic [2:0]    erase_code
);
  logic [15:0] mem [WORDS];

  assign rd_word = mem[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= 16'hFFFF;
    end else if (erase_en) begin
      for (int i = 0; i < WORDS; i++)
        if (int'(erase_code) >= NBLK || (i / BW) == int'(erase_code)) mem[i] <= 16'hFFFF;
    end else if (prog_en) begin
      mem[prog_idx] <= mem[prog_idx] & (prog_data | ~prog_mask);
    end
  end

  // Checker state: remembers the word a program touched.
  logic          pchk_q;
  logic [IW-1:0] pidx_q;
  logic [15:0]   pold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pchk_q <= 1'b0;
      pidx_q <= '0;
      pold_q <= '0;
    end else begin
      pchk_q <= prog_en && !erase_en;
      pidx_q <= prog_idx;
      pold_q <= mem[prog_idx];
    end
  end

  AST_PROG_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    pchk_q |-> ((mem[pidx_q] & ~pold_q) == 16'h0000)); // R8

endmodule

// File: rtl/flash_bus_slave.sv
module flash_bus_slave
  import flash_pkg::*;
#(
  parameter int          AW       = 24,
  parameter int          WORDS    = 64,
  parameter int          NBLK     = 4,
  parameter logic [63:0] BOOT_VEC = 64'h0400_03FE_0200_0F00,
  localparam int         IW       = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_strap,
  input  logic          nv_halt,
  input  logic          nv_noboot,
  input  logic [AW-1:0] win_base,
  input  logic [1:0]    space_sel,
  input  logic [1:0]    ctl_op,
  input  logic          req,
  input  logic          rw,
  input  logic [1:0]    size,
  input  logic [2:0]    fc,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wdata,
  output logic          ack,
  output logic          nak,
  output logic [15:0]   rdata
);
  function automatic logic [15:0] boot_word(input logic [1:0] k);
    return BOOT_VEC[{k, 4'b0000} +: 16];
  endfunction

  logic          stop_q, boot_q, beat2_q, b2_boot_q, ack_q, nak_q;
  arm_e          arm_q;
  logic [1:0]    b2_bidx_q;
  logic [IW-1:0] b2_idx_q;
  logic [15:0]   rdata_q;

  logic          hit_arr, hit_boot, sp_ok, aligned;
  logic [IW-1:0] widx, rd_idx;
  logic [1:0]    bidx;
  logic [15:0]   arr_word, src_word, first_data;
  logic          fire, claim, rd_ok, wr_ok, accept, reject;
  logic          prog_ev, erase_ev, boot_done, long_start;

  flash_decode #(.AW(AW), .WORDS(WORDS)) u_dec (
    .addr(addr), .base(win_base), .fc(fc), .sel(space_sel), .size(size), .rw(rw),
    .boot_act(boot_q), .hit_arr(hit_arr), .hit_boot(hit_boot), .widx(widx),
    .bidx(bidx), .sp_ok(sp_ok), .aligned(aligned)
  );

  assign rd_idx = beat2_q ? b2_idx_q : widx;

  flash_array #(.WORDS(WORDS), .NBLK(NBLK)) u_arr (
    .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_word(arr_word),
    .prog_en(prog_ev), .prog_idx(widx), .prog_mask(lane_mask(size, addr[0])),
    .prog_data(size == SZ_BYTE ? {wdata[7:0], wdata[7:0]} : wdata),
    .erase_en(erase_ev), .erase_code(addr[3:1])
  );

  always_comb begin
    fire       = req && !beat2_q;
    claim      = hit_boot || hit_arr;
    rd_ok      = !stop_q && (hit_boot || (hit_arr && sp_ok)) && aligned;
    wr_ok      = !stop_q && hit_arr && sp_ok &&
                 ((arm_q == ARM_ERS) ||
                  (arm_q == ARM_PGM && size != SZ_LONG && aligned));
    accept     = fire && claim && (rw ? rd_ok : wr_ok);
    reject     = fire && claim && !accept;
    prog_ev    = accept && !rw && (arm_q == ARM_PGM);
    erase_ev   = accept && !rw && (arm_q == ARM_ERS);
    long_start = accept && rw && (size == SZ_LONG);
    src_word   = hit_boot ? boot_word(bidx) : arr_word;
    first_data = (size == SZ_BYTE) ? pick_byte(src_word, addr[0]) : src_word;
    boot_done  = (accept && rw && hit_boot && bidx == 2'd3) ||
                 (beat2_q && b2_boot_q && b2_bidx_q == 2'd3);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q    <= nv_halt | ~cfg_strap;
      boot_q    <= ~nv_noboot & ~nv_halt & cfg_strap;
      arm_q     <= ARM_NONE;
      beat2_q   <= 1'b0;
      b2_boot_q <= 1'b0;
      b2_bidx_q <= '0;
      b2_idx_q  <= '0;
      ack_q     <= 1'b0;
      nak_q     <= 1'b0;
      rdata_q   <= '0;
    end else begin
      ack_q   <= 1'b0;
      nak_q   <= 1'b0;
      rdata_q <= '0;
      beat2_q <= 1'b0;
      if (beat2_q) begin
        ack_q   <= 1'b1;
        rdata_q <= b2_boot_q ? boot_word(b2_bidx_q) : arr_word;
      end else if (accept) begin
        ack_q <= 1'b1;
        if (rw) rdata_q <= first_data;
        if (long_start) begin
          beat2_q   <= 1'b1;
          b2_boot_q <= hit_boot;
          b2_bidx_q <= bidx + 2'd1;
          b2_idx_q  <= widx + 1'b1;
        end
      end else if (reject) begin
        nak_q <= 1'b1;
      end
      if (boot_done) boot_q <= 1'b0;
      if (prog_ev || erase_ev) arm_q <= ARM_NONE;
      case (ctl_op)
        OP_ARM_PGM: arm_q  <= ARM_PGM;
        OP_ARM_ERS: arm_q  <= ARM_ERS;
        OP_RUN:     stop_q <= 1'b0;
        default: ;
      endcase
    end
  end

  assign ack   = ack_q;
  assign nak   = nak_q;
  assign rdata = rdata_q;

  AST_ACK_NAK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack && nak)); // R7
  AST_HALT_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !$past(beat2_q)) |-> !$past(stop_q)); // R1
  AST_BOOT_NO_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(boot_q)); // R3
  AST_LONG_TWO_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
    beat2_q |=> (ack && !beat2_q)); // R5

endmodule

// File: tb/test_flash_bus_slave.sv
module test_flash_bus_slave;
  localparam int          AW = 24;
  localparam int          NW = 64;
  localparam int          NB = 4;
  localparam logic [63:0] BV = 64'h0400_03FE_0200_0F00;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_strap = 1'b1, nv_halt = 1'b0, nv_noboot = 1'b0;
  logic [AW-1:0] win_base = 24'h001000;
  logic [1:0] space_sel = 2'b00, ctl_op = 2'b00, size = 2'b00;
  logic req = 1'b0, rw = 1'b1;
  logic [2:0] fc = 3'b110;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = '0;
  logic ack, nak;
  logic [15:0] rdata;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  logic [15:0] m_mem [NW];
  bit m_stop, m_boot;
  int m_arm;

  always #10 clk = ~clk;

  flash_bus_slave #(.AW(AW), .WORDS(NW), .NBLK(NB), .BOOT_VEC(BV)) i_flash_bus_slave (
    .clk(clk), .rst_n(rst_n), .cfg_strap(cfg_strap), .nv_halt(nv_halt), .nv_noboot(nv_noboot),
    .win_base(win_base), .space_sel(space_sel), .ctl_op(ctl_op), .req(req), .rw(rw),
    .size(size), .fc(fc), .addr(addr), .wdata(wdata), .ack(ack), .nak(nak), .rdata(rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit space_ok(input logic [1:0] sel, input logic [2:0] f);
    bit is_d = (f[1:0] == 2'b01), is_p = (f[1:0] == 2'b10);
    return (is_d && !sel[1]) || (is_p && !sel[0]);
  endfunction

  function automatic logic [15:0] bword(input int k);
    return BV[k*16 +: 16];
  endfunction

  task automatic do_reset(input bit halt, input bit strap, input bit noboot);
    @(negedge clk);
    rst_n = 1'b0; nv_halt = halt; cfg_strap = strap; nv_noboot = noboot;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_stop = halt || !strap;
    m_boot = !noboot && !m_stop;
    m_arm  = 0;
    for (int i = 0; i < NW; i++) m_mem[i] = 16'hFFFF;
    chk("R1 reset idle", {ack, nak}, 2'b00);
  endtask

  task automatic ctl(input logic [1:0] op);
    @(negedge clk); ctl_op = op;
    @(negedge clk); ctl_op = 2'b00;
    if (op == 2'b01) m_arm = 1;
    else if (op == 2'b10) m_arm = 2;
    else if (op == 2'b11) m_stop = 0;
  endtask

  task automatic xfer(input bit rd, input logic [1:0] sz, input logic [AW-1:0] a,
                      input logic [2:0] f, input logic [15:0] wd, input string tag);
    logic [AW-1:0] off = a - win_base;
    bit hwin  = off < AW'(2 * NW);
    bit hboot = m_boot && rd && f[1:0] == 2'b10 && a < 8;
    bit al    = (sz == 2'b00) || (sz == 2'b01 && !a[0]) || (sz == 2'b10 && a[1:0] == 2'b00);
    int wi    = int'(off[6:1]);
    bit ok;
    logic [15:0] w1, w2;
    if (rd) ok = !m_stop && (hboot || (hwin && space_ok(space_sel, f))) && al;
    else ok = !m_stop && hwin && space_ok(space_sel, f) &&
              (m_arm == 2 || (m_arm == 1 && sz != 2'b10 && al));
    w1 = hboot ? bword(int'(a[2:1])) : m_mem[wi];
    w2 = hboot ? bword(int'(a[2:1]) + 1) : m_mem[(wi + 1) % NW];
    if (sz == 2'b00) w1 = a[0] ? {8'h00, w1[7:0]} : {8'h00, w1[15:8]};
    @(negedge clk);
    req = 1'b1; rw = rd; size = sz; addr = a; fc = f; wdata = wd;
    @(negedge clk);
    req = 1'b0;
    chk({tag, " ack/nak"}, {ack, nak}, {(hboot || hwin) && ok, (hboot || hwin) && !ok});
    if (rd && ok) chk({tag, " data"}, rdata, w1);
    if (rd && ok && sz == 2'b10) begin
      @(negedge clk);
      chk({tag, " R5 beat2"}, {ack, rdata}, {1'b1, w2});
    end
    if (rd && ok && hboot && (a[2:1] == 2'd3 || (sz == 2'b10 && a[2:1] == 2'd2))) m_boot = 0;
    if (!rd && ok) begin
      if (m_arm == 1) begin
        if (sz == 2'b01) m_mem[wi] &= wd;
        else if (a[0]) m_mem[wi][7:0] &= wd[7:0];
        else m_mem[wi][15:8] &= wd[7:0];
      end else begin
        for (int i = 0; i < NW; i++)
          if (int'(a[3:1]) >= NB || i / (NW / NB) == int'(a[3:1])) m_mem[i] = 16'hFFFF;
      end
      m_arm = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // R1: halt from the nonvolatile bit, then from the strap
    do_reset(1, 1, 0);
    xfer(1, 2'b01, 24'h001000, 3'b110, 0, "R1 halted window read");
    xfer(1, 2'b01, 24'h000000, 3'b110, 0, "R1 halted boot ignored");
    do_reset(0, 0, 0);
    xfer(1, 2'b00, 24'h001003, 3'b101, 0, "R1 strap halt");
    ctl(2'b11);
    xfer(1, 2'b01, 24'h001002, 3'b101, 0, "R1 after run R9 erased");
    // R2 boot disabled
    do_reset(0, 1, 1);
    xfer(1, 2'b01, 24'h000000, 3'b110, 0, "R2 noboot");
    // R2/R3 bootstrap sequence
    do_reset(0, 1, 0);
    space_sel = 2'b01;
    xfer(1, 2'b01, 24'h000000, 3'b110, 0, "R2 boot word0");
    xfer(1, 2'b01, 24'h000002, 3'b101, 0, "R2 data space not boot");
    xfer(1, 2'b01, 24'h000002, 3'b110, 0, "R2 boot word1");
    xfer(1, 2'b10, 24'h000004, 3'b110, 0, "R2 boot long");
    xfer(1, 2'b01, 24'h000000, 3'b110, 0, "R3 boot ended");
    space_sel = 2'b00;
    // R8 program, R4 byte lanes, R10 rejects
    xfer(0, 2'b01, 24'h001010, 3'b101, 16'h1234, "R10 unarmed write");
    ctl(2'b01);
    xfer(0, 2'b01, 24'h001011, 3'b101, 16'h0000, "R10 misaligned program");
    xfer(0, 2'b10, 24'h001010, 3'b101, 16'h0000, "R10 long program");
    xfer(0, 2'b01, 24'h001010, 3'b101, 16'hA5C3, "R8 word program");
    xfer(1, 2'b01, 24'h001010, 3'b101, 0, "R8 readback");
    ctl(2'b01);
    xfer(0, 2'b01, 24'h001010, 3'b101, 16'hFF0F, "R8 no set back");
    xfer(1, 2'b00, 24'h001010, 3'b101, 0, "R4 even byte");
    xfer(1, 2'b00, 24'h001011, 3'b101, 0, "R4 odd byte");
    ctl(2'b01);
    xfer(0, 2'b00, 24'h001013, 3'b101, 16'h003C, "R8 byte program");
    xfer(1, 2'b10, 24'h001010, 3'b101, 0, "R5 long read");
    xfer(1, 2'b11, 24'h001010, 3'b101, 0, "R10 bad size");
    // R6 spaces, R7 window
    space_sel = 2'b10;
    xfer(1, 2'b01, 24'h001010, 3'b101, 0, "R6 data refused");
    space_sel = 2'b11;
    xfer(1, 2'b01, 24'h001010, 3'b110, 0, "R6 none");
    space_sel = 2'b00;
    xfer(1, 2'b01, 24'h00107E, 3'b101, 0, "R7 last word");
    xfer(1, 2'b01, 24'h001080, 3'b101, 0, "R7 past end");
    xfer(1, 2'b01, 24'h000FFE, 3'b101, 0, "R7 below base");
    // R9 erase block and whole array
    ctl(2'b10);
    xfer(0, 2'b01, 24'h001000, 3'b101, 0, "R9 erase block0");
    xfer(1, 2'b01, 24'h001010, 3'b101, 0, "R9 block0 erased");
    for (int k = 0; k < 40; k++) begin
      ctl(2'b01);
      xfer(0, 2'b01, win_base + AW'(2 * k), 3'b101, 16'($urandom), "R8 fill");
    end
    ctl(2'b10);
    xfer(0, 2'b01, 24'h001002, 3'b110, 0, "R9 erase block1");
    xfer(1, 2'b01, 24'h001020, 3'b101, 0, "R9 block1");
    xfer(1, 2'b01, 24'h001040, 3'b101, 0, "R9 block2 kept");
    ctl(2'b10);
    xfer(0, 2'b01, 24'h00100E, 3'b101, 0, "R9 erase all");
    xfer(1, 2'b01, 24'h001040, 3'b101, 0, "R9 all erased");
    // random mix
    for (int n = 0; n < 600; n++) begin
      int r = int'($urandom % 12);
      logic [2:0] fcs [5] = '{3'b101, 3'b110, 3'b001, 3'b010, 3'b111};
      if (r == 0) ctl(2'b01);
      else if (r == 1 && ($urandom % 4) == 0) ctl(2'b10);
      else if (r == 2) space_sel = 2'($urandom);
      else begin
        logic [1:0] sz = ($urandom % 8 == 0) ? 2'($urandom) : 2'($urandom % 3);
        logic [AW-1:0] a = win_base - 24'd4 + AW'($urandom % 136);
        if ($urandom % 2) a[0] = 1'b0;
        xfer(($urandom % 2) == 1, sz, a, fcs[$urandom % 5], 16'($urandom), "R6 R8 random");
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule